// File: doc/BRIEF.md
# ADC Startup Muting Sequencer

This block sits between a stereo ADC decimation path and the serial output. It holds both sample outputs at two's-complement zero while the converter settles after power-up. It watches the left and right channel enable bits. When either one rises, it starts a settling period. The period is counted in sample-rate strobes, not in system clocks, and its length is either long or short as chosen by a select bit. When the period ends, input samples pass straight through to the outputs.

A busy flag shows that the settling period is running. A new rising edge on either enable during a running period restarts the count from zero. When both enables are low, the block holds the outputs at zero and drops the busy flag. The length select is sampled at the trigger, so a change in the middle of a period does not move its end. The reset input is asynchronous and active low, and the block releases it synchronously inside.

Top module: `adc_startup_mute`

## Requirements
- R1: A 0-to-1 change of `en_l` or `en_r` is a trigger. `busy` is 1 from the clock cycle after the trigger.
- R2: With `len_sel` = 0 at the trigger, `busy` stays 1 through 1058 accepted strobes. It goes to 0 in the cycle after the 1059th strobe that arrives while busy.
- R3: With `len_sel` = 1 at the trigger, the period is 267 accepted strobes, with the same timing as R2.
- R4: The block captures `len_sel` at the trigger. A change of `len_sel` during a running period does not change that period's length.
- R5: Only cycles with `smp_stb` = 1 advance the count. Any number of clock cycles without a strobe leaves `busy` high. A strobe in the trigger cycle itself is not counted.
- R6: In the trigger cycle and in every cycle where `busy` is 1, both `dout_l` and `dout_r` are 0, even when only one channel is enabled.
- R7: When `busy` is 0 and at least one enable is 1, `dout_l` equals `din_l` and `dout_r` equals `din_r` in the same cycle.
- R8: A rising edge on either enable while `busy` is 1 restarts the count from zero. A full new period then follows.
- R9: When `en_l` and `en_r` are both 0, both outputs are 0 in that cycle and `busy` is 0 from the next cycle.
- R10: While `rst_n` is 0, `busy` is 0 and the enable history is cleared. An enable held at 1 across reset therefore triggers a period once the reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | One-cycle sample-rate strobe |
| en_l | input | 1 | Left channel converter enable |
| en_r | input | 1 | Right channel converter enable |
| len_sel | input | 1 | Settling length: 0 long (1059), 1 short (267) |
| din_l | input | DATA_W | Left sample from decimation path |
| din_r | input | DATA_W | Right sample from decimation path |
| dout_l | output | DATA_W | Gated left sample |
| dout_r | output | DATA_W | Gated right sample |
| busy | output | 1 | Settling period in progress |

## Verification
Some properties are checked on every cycle. The count never runs past the selected terminal value, and it holds still without a strobe. A trigger is always followed by `busy`, and an idle state always clears it. The outputs are zero whenever `busy` is set, and `busy` only falls on a strobe or when both channels go idle. Other behaviour is only visible in the bench scenarios: the exact length of each period at both settings, that the length latched at the trigger survives a later change of the select, the full new period after a restart, and a trigger from an enable held high across reset.

// File: rtl/adc_mute_pkg.sv
package adc_mute_pkg;

  // Settling length choice, as seen on the select input
  typedef enum logic {
    LEN_LONG  = 1'b0,
    LEN_SHORT = 1'b1
  } len_sel_e;

  // Index of the channels inside the internal arrays
  localparam int unsigned CH_LEFT  = 0;
  localparam int unsigned CH_RIGHT = 1;
  localparam int unsigned NUM_CH   = 2;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ams_rst_sync.sv
module ams_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/ams_edge_detect.sv
module ams_edge_detect #(
  parameter int unsigned NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] en,
  output logic           trig,
  output logic           any_en
);

  logic [NCH-1:0] prev_q;
  logic [NCH-1:0] rise;

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prev_q[g] <= 1'b0;
        end else begin
          prev_q[g] <= en[g];
        end
      end
      assign rise[g] = en[g] & ~prev_q[g];
    end
  endgenerate

  assign trig   = |rise;
  assign any_en = |en;

endmodule

// File: rtl/ams_startup_counter.sv
module ams_startup_counter
  import adc_mute_pkg::*;
#(
  parameter int unsigned LONG_LEN  = 1059,
  parameter int unsigned SHORT_LEN = 267
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic any_en,
  input  logic smp_stb,
  input  logic len_sel,
  output logic busy
);

  localparam int unsigned MAX_LEN = max_u(LONG_LEN, SHORT_LEN);
  localparam int unsigned CNT_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_LEN - 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_LEN - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             len_q, len_d;
  logic [CNT_W-1:0] last;
  logic             upd_en;

  assign last = (len_sel_e'(len_q) == LEN_SHORT) ? SHORT_LAST : LONG_LAST;

  // Next-state logic: idle clears, trigger restarts, strobe advances
  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    len_d  = len_q;
    upd_en = 1'b0;
    if (!any_en) begin
      busy_d = 1'b0;
      cnt_d  = '0;
      upd_en = 1'b1;
    end else if (trig) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      len_d  = len_sel;
      upd_en = 1'b1;
    end else if (busy_q && smp_stb) begin
      upd_en = 1'b1;
      if (cnt_q == last) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d  = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      len_q  <= 1'b0;
    end else if (upd_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      len_q  <= len_d;
    end
  end

  assign busy = busy_q;

  p_trig_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && any_en) |=> busy_q);

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= last));

  p_hold_no_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !smp_stb && !trig && any_en) |=> ($stable(cnt_q) && busy_q));

  p_idle_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !any_en |=> !busy_q);

  p_fall_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(smp_stb) || !$past(any_en)));

endmodule

// File: rtl/ams_output_gate.sv
module ams_output_gate #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned NCH    = 2
) (
  input  logic              mute,
  input  logic [DATA_W-1:0] din  [NCH],
  output logic [DATA_W-1:0] dout [NCH]
);

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      assign dout[g] = mute ? '0 : din[g];
    end
  endgenerate

endmodule

// File: rtl/adc_startup_mute.sv
module adc_startup_mute
  import adc_mute_pkg::*;
#(
  parameter int unsigned DATA_W    = 24,
  parameter int unsigned LONG_LEN  = 1059,
  parameter int unsigned SHORT_LEN = 267
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_stb,
  input  logic              en_l,
  input  logic              en_r,
  input  logic              len_sel,
  input  logic [DATA_W-1:0] din_l,
  input  logic [DATA_W-1:0] din_r,
  output logic [DATA_W-1:0] dout_l,
  output logic [DATA_W-1:0] dout_r,
  output logic              busy
);

  logic              rst_n_i;
  logic [NUM_CH-1:0] en_vec;
  logic              trig;
  logic              any_en;
  logic              busy_w;
  logic              mute;
  logic [DATA_W-1:0] din_a  [NUM_CH];
  logic [DATA_W-1:0] dout_a [NUM_CH];

  assign en_vec[CH_LEFT]  = en_l;
  assign en_vec[CH_RIGHT] = en_r;
  assign din_a[CH_LEFT]   = din_l;
  assign din_a[CH_RIGHT]  = din_r;

  ams_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  ams_edge_detect #(.NCH(NUM_CH)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .en     (en_vec),
    .trig   (trig),
    .any_en (any_en)
  );

  ams_startup_counter #(
    .LONG_LEN  (LONG_LEN),
    .SHORT_LEN (SHORT_LEN)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .trig    (trig),
    .any_en  (any_en),
    .smp_stb (smp_stb),
    .len_sel (len_sel),
    .busy    (busy_w)
  );

  // Muted while settling, in the trigger cycle, and while both channels are off
  assign mute = busy_w | trig | ~any_en;

  ams_output_gate #(
    .DATA_W (DATA_W),
    .NCH    (NUM_CH)
  ) u_gate (
    .mute (mute),
    .din  (din_a),
    .dout (dout_a)
  );

  assign dout_l = dout_a[CH_LEFT];
  assign dout_r = dout_a[CH_RIGHT];
  assign busy   = busy_w;

  p_busy_mutes_r6: assert property (@(posedge clk) disable iff (!rst_n_i)
    busy_w |-> (dout_l == '0 && dout_r == '0));

  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!en_l && !en_r) |-> (dout_l == '0 && dout_r == '0));

endmodule

// File: tb/test_adc_startup_mute.sv
module test_adc_startup_mute;

  localparam int unsigned DW    = 24;
  localparam int unsigned LONGN = 1059;
  localparam int unsigned SHRTN = 267;
  localparam int unsigned VW    = 4 + 2*DW + 1 + 2*DW;
  localparam int unsigned NVEC  = 8;

  localparam logic [DW-1:0] DA = 24'h123456;
  localparam logic [DW-1:0] DB = 24'hFEDCBA;
  localparam logic [DW-1:0] DC = 24'h800001;
  localparam logic [DW-1:0] DD = 24'h7FFFFF;
  localparam logic [DW-1:0] Z  = 24'h000000;

  // {en_l, en_r, len_sel, stb, din_l, din_r, exp_busy, exp_dout_l, exp_dout_r}
  localparam logic [VW-1:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b0, 1'b1, DA, DB, 1'b0, Z, Z},  // R9 idle
    {1'b1, 1'b0, 1'b1, 1'b0, DA, DB, 1'b0, Z, Z},  // R6 trigger cycle muted
    {1'b1, 1'b0, 1'b1, 1'b1, DC, DD, 1'b1, Z, Z},  // R1 busy, R6 muted
    {1'b1, 1'b1, 1'b0, 1'b0, DC, DD, 1'b1, Z, Z},  // R8 restart edge
    {1'b1, 1'b1, 1'b0, 1'b1, DA, DB, 1'b1, Z, Z},  // R6 muted both
    {1'b0, 1'b0, 1'b0, 1'b0, DA, DB, 1'b1, Z, Z},  // R9 outputs zero now
    {1'b0, 1'b0, 1'b0, 1'b0, DA, DB, 1'b0, Z, Z},  // R9 busy cleared
    {1'b0, 1'b1, 1'b0, 1'b0, DC, DD, 1'b0, Z, Z}   // R1 right trigger
  };

  logic          clk;
  logic          rst_n;
  logic          smp_stb;
  logic          en_l;
  logic          en_r;
  logic          len_sel;
  logic [DW-1:0] din_l;
  logic [DW-1:0] din_r;
  logic [DW-1:0] dout_l;
  logic [DW-1:0] dout_r;
  logic          busy;

  int n_run;
  int n_fail;

  adc_startup_mute #(.DATA_W(DW), .LONG_LEN(LONGN), .SHORT_LEN(SHRTN)) i_adc_startup_mute (
    .clk     (clk),
    .rst_n   (rst_n),
    .smp_stb (smp_stb),
    .en_l    (en_l),
    .en_r    (en_r),
    .len_sel (len_sel),
    .din_l   (din_l),
    .din_r   (din_r),
    .dout_l  (dout_l),
    .dout_r  (dout_r),
    .busy    (busy)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock with the given strobe; inputs change 1 time unit after the edge
  task automatic tick(input logic stb);
    smp_stb = stb;
    @(posedge clk);
    #1;
    smp_stb = 1'b0;
  endtask

  // start a period from idle: leaves the bench one cycle after the trigger
  task automatic start_period(input logic sel, input logic use_left);
    en_l = 1'b0; en_r = 1'b0;
    tick(1'b0);
    len_sel = sel;
    if (use_left) en_l = 1'b1; else en_r = 1'b1;
    tick(1'b1);             // strobe in trigger cycle must not count (R5)
  endtask

  // give n strobes and report whether busy stayed high after each
  task automatic strobes(input int n, output logic all_busy);
    all_busy = 1'b1;
    for (int k = 0; k < n; k++) begin
      tick(1'b1);
      if (busy !== 1'b1) all_busy = 1'b0;
    end
  endtask

  initial begin
    logic ok;
    n_run = 0; n_fail = 0;
    rst_n = 1'b0; smp_stb = 1'b0; en_l = 1'b0; en_r = 1'b0; len_sel = 1'b0;
    din_l = DA; din_r = DB;
    repeat (3) @(posedge clk);
    #1;
    check("R10 busy in reset", 64'(busy), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R10 busy after release", 64'(busy), 64'd0);

    // vector table walk
    for (int i = 0; i < NVEC; i++) begin
      en_l    = VEC[i][VW-1];
      en_r    = VEC[i][VW-2];
      len_sel = VEC[i][VW-3];
      smp_stb = VEC[i][VW-4];
      din_l   = VEC[i][4*DW:3*DW+1];
      din_r   = VEC[i][3*DW:2*DW+1];
      #1;
      check($sformatf("R6/R9 vec%0d busy", i), 64'(busy), 64'(VEC[i][2*DW]));
      check($sformatf("R6/R9 vec%0d dout_l", i), 64'(dout_l), 64'(VEC[i][2*DW-1:DW]));
      check($sformatf("R6/R9 vec%0d dout_r", i), 64'(dout_r), 64'(VEC[i][DW-1:0]));
      @(posedge clk);
      #1;
      smp_stb = 1'b0;
    end

    // R3: short length, exact boundary
    start_period(1'b1, 1'b1);
    din_l = DC; din_r = DD;
    check("R1 busy after trigger", 64'(busy), 64'd1);
    strobes(SHRTN - 1, ok);
    check("R3 busy through 266 strobes", 64'(ok), 64'd1);
    check("R6 muted before end", 64'(dout_l), 64'd0);
    tick(1'b1);
    check("R3 busy falls after 267th", 64'(busy), 64'd0);
    check("R7 left passes", 64'(dout_l), 64'(DC));
    check("R7 right passes", 64'(dout_r), 64'(DD));

    // R2 and R5: long length with a long gap of no strobes
    start_period(1'b0, 1'b0);
    repeat (1500) tick(1'b0);
    check("R5 busy held without strobes", 64'(busy), 64'd1);
    strobes(LONGN - 1, ok);
    check("R2 busy through 1058 strobes", 64'(ok), 64'd1);
    tick(1'b1);
    check("R2 busy falls after 1059th", 64'(busy), 64'd0);
    check("R7 right passes (one channel on)", 64'(dout_r), 64'(DD));

    // R4: select changes after trigger are ignored
    start_period(1'b1, 1'b1);
    len_sel = 1'b0;
    strobes(SHRTN - 1, ok);
    check("R4 busy through short period", 64'(ok), 64'd1);
    tick(1'b1);
    check("R4 ends at short length", 64'(busy), 64'd0);

    // R8: restart while busy
    start_period(1'b1, 1'b1);
    strobes(200, ok);
    en_r = 1'b1;
    #1;
    check("R8 restart cycle muted", 64'(dout_l), 64'd0);
    tick(1'b0);
    strobes(SHRTN - 1, ok);
    check("R8 busy for full new period", 64'(ok), 64'd1);
    tick(1'b1);
    check("R8 ends after new period", 64'(busy), 64'd0);

    // R9: drop both enables mid-period
    start_period(1'b0, 1'b1);
    strobes(10, ok);
    en_l = 1'b0; en_r = 1'b0;
    #1;
    check("R9 outputs zero when idle", 64'(dout_r), 64'd0);
    tick(1'b0);
    check("R9 busy cleared", 64'(busy), 64'd0);

    // R10: enable held across reset triggers afterwards
    en_l = 1'b1;
    tick(1'b0);
    rst_n = 1'b0;
    #1;
    check("R10 busy forced low", 64'(busy), 64'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check("R10 trigger after release", 64'(busy), 64'd1);
    check("R10 outputs muted", 64'(dout_l), 64'd0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule